// File: doc/BRIEF.md
# Graphics DRAM Command Decoder

This block turns the command pins of a graphics SDRAM device model into one decoded command per rising clock edge. On each edge it looks at the chip-select, row-strobe, column-strobe and write-enable pins, at the active-low clock-enable pin, and at three address bits that pick among sub-commands. It also compares clock-enable with the value it held on the edge before. From these it raises one bit of a one-hot command strobe for the next cycle. It also reports an auto-precharge flag, a write-mask kind and a training indication. A pin pattern that matches no command raises an illegal-command flag instead of a strobe.

The read and write pin patterns are split further by the three address bits. This gives masked writes, FIFO loading and the read and write training commands. While the address-training mode input is high, the read pin pattern is decoded as a plain read and the address bits are not looked at. Clock-enable transitions give power-down entry and exit and self-refresh entry. When clock-enable is high on both edges the device is powered down and nothing is decoded. Address demultiplexing, bank timing and data handling belong to other blocks.

Top module: `gcdec_top`

## Requirements
- R1: With csN high, no strobe fires except power-down entry or exit, and illegalCmd stays low.
- R2: With csN low and ckeN low on both the previous and the current edge, the pins {rasN,casN,weN} decode as 000 mode-set (bit 0), 001 refresh (bit 9), 011 activate (bit 1), and 010 precharge. Precharge is one bank (bit 7) when selLo is 0 and all banks (bit 8) when selLo is 1.
- R3: Pin pattern 101 is the read group. With {selHi,selMid} = 00 it is a read (bit 2) with autoPre = selLo. {selHi,selMid,selLo} = 100 is FIFO load (bit 3) and 110 is read training (bit 4), each with trainActive high. Every other address value is illegal.
- R4: Pin pattern 100 is the write group. {selHi,selMid} = 00, 01 and 10 give a write (bit 5) with maskKind 0 (none), 1 (single byte) and 2 (double byte), and autoPre = selLo. 110 is write training (bit 6) with trainActive high. 111 is illegal.
- R5: Pin pattern 001 with csN low, ckeN low on the previous edge and high on the current edge is self-refresh entry (bit 10).
- R6: Deselect or NOP with ckeN going low to high is power-down entry (bit 11), and with ckeN going high to low is power-down or self-refresh exit (bit 12). Any other command on such a transition is illegal. With ckeN high on both edges nothing fires and illegalCmd stays low.
- R7: While addrTrain is high, pin pattern 101 decodes as a read (bit 2) with autoPre, maskKind and trainActive all 0, whatever the select bits are.
- R8: Every pattern not listed above sets illegalCmd for one cycle with all strobe bits 0. Pattern 110 with csN low and ckeN low on both edges is one such pattern.
- R9: Outputs are registered: a command sampled on one edge is visible for exactly the following cycle and is zero after the next edge unless repeated. At most one strobe bit is ever set. A low rstN at an edge clears all outputs and makes the previous clock-enable value read as low.
- R10: autoPre is high only with the read or write strobe, maskKind is nonzero only with the write strobe, and trainActive is high only with the FIFO-load or training strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock, rising edge samples |
| rstN | input | 1 | Active-low synchronous reset |
| csN | input | 1 | Chip select, active low |
| rasN | input | 1 | Row strobe pin, active low |
| casN | input | 1 | Column strobe pin, active low |
| weN | input | 1 | Write-enable pin, active low |
| ckeN | input | 1 | Clock enable, active low |
| selHi | input | 1 | High sub-command select address bit |
| selMid | input | 1 | Middle sub-command select address bit |
| selLo | input | 1 | Auto-precharge / all-bank select address bit |
| addrTrain | input | 1 | Address-training mode is active |
| cmdStrobe | output | 13 | One-hot decoded command, bit map in R2 to R6 |
| illegalCmd | output | 1 | Unrecognised pin pattern |
| autoPre | output | 1 | Access closes its row on completion |
| maskKind | output | 2 | Write mask: 0 none, 1 single byte, 2 double byte |
| trainActive | output | 1 | Command is a training or FIFO-load command |

## Verification
The bench goes after the address combinations next to the legal sub-commands: the read group with select values 01x, 101 and 111, and write training with selLo set. A decoder that matched on only two of the three bits would take these for FIFO load or training when they should be illegal. It drives clock-enable transitions with real commands, and held-high clock-enable with garbage on the pins. A design that ignored the previous clock-enable would decode commands during power-down or miss self-refresh entry. It also runs reads in address-training mode with every select value. A design that kept the normal address decoding in that mode would flag illegal commands or set autoPre there.

// File: rtl/gcdec_pkg.sv
package gcdec_pkg;

  localparam int NUM_CMDS = 13;
  localparam int MASK_W   = 2;
  localparam int SEL_W    = $clog2(NUM_CMDS);

  // Strobe bit positions; the bench and the brief rely on this order.
  typedef enum logic [SEL_W-1:0] {
    CMD_MODESET  = 4'd0,
    CMD_OPEN     = 4'd1,
    CMD_READ     = 4'd2,
    CMD_FIFOLOAD = 4'd3,
    CMD_RDTRAIN  = 4'd4,
    CMD_WRITE    = 4'd5,
    CMD_WRTRAIN  = 4'd6,
    CMD_CLOSE    = 4'd7,
    CMD_CLOSEALL = 4'd8,
    CMD_REFRESH  = 4'd9,
    CMD_SELFREF  = 4'd10,
    CMD_PDENTER  = 4'd11,
    CMD_PDEXIT   = 4'd12
  } cmdSel_e;

  localparam logic [MASK_W-1:0] MASK_NONE   = MASK_W'(0);
  localparam logic [MASK_W-1:0] MASK_SINGLE = MASK_W'(1);
  localparam logic [MASK_W-1:0] MASK_DOUBLE = MASK_W'(2);

  // Pin patterns {rasN, casN, weN}
  localparam logic [2:0] PAT_MODESET = 3'b000;
  localparam logic [2:0] PAT_REFRESH = 3'b001;
  localparam logic [2:0] PAT_CLOSE   = 3'b010;
  localparam logic [2:0] PAT_OPEN    = 3'b011;
  localparam logic [2:0] PAT_WRITE   = 3'b100;
  localparam logic [2:0] PAT_READ    = 3'b101;

  // Strobes from the control half to the output register half.
  typedef struct packed {
    logic              fire;
    logic              illegal;
    cmdSel_e           sel;
    logic              autoPre;
    logic [MASK_W-1:0] maskKind;
    logic              train;
  } decStrobe_t;

endpackage

// File: rtl/gcdec_ctrl.sv
module gcdec_ctrl
  import gcdec_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       csN,
  input  logic       rasN,
  input  logic       casN,
  input  logic       weN,
  input  logic       ckeN,
  input  logic       selHi,
  input  logic       selMid,
  input  logic       selLo,
  input  logic       addrTrain,
  output decStrobe_t dec
);

  logic       prevCke;
  logic       nopLike;
  logic [2:0] pinPat;

  always_ff @(posedge clk) begin
    if (!rstN) prevCke <= 1'b0;
    else       prevCke <= ckeN;
  end

  assign nopLike = csN | (rasN & casN & weN);
  assign pinPat  = {rasN, casN, weN};

  always_comb begin
    dec          = '0;
    dec.sel      = CMD_MODESET;
    dec.maskKind = MASK_NONE;
    unique case ({prevCke, ckeN})
      2'b01: begin
        if (nopLike) begin
          dec.fire = 1'b1; dec.sel = CMD_PDENTER;
        end else if (pinPat == PAT_REFRESH) begin
          dec.fire = 1'b1; dec.sel = CMD_SELFREF;
        end else begin
          dec.illegal = 1'b1;
        end
      end
      2'b10: begin
        if (nopLike) begin
          dec.fire = 1'b1; dec.sel = CMD_PDEXIT;
        end else begin
          dec.illegal = 1'b1;
        end
      end
      2'b11: begin
        // powered down: pins are not looked at
      end
      default: begin
        if (!nopLike) begin
          unique case (pinPat)
            PAT_MODESET: begin dec.fire = 1'b1; dec.sel = CMD_MODESET; end
            PAT_REFRESH: begin dec.fire = 1'b1; dec.sel = CMD_REFRESH; end
            PAT_OPEN:    begin dec.fire = 1'b1; dec.sel = CMD_OPEN; end
            PAT_CLOSE: begin
              dec.fire = 1'b1;
              dec.sel  = selLo ? CMD_CLOSEALL : CMD_CLOSE;
            end
            PAT_READ: begin
              if (addrTrain) begin
                dec.fire = 1'b1; dec.sel = CMD_READ;
              end else begin
                unique case ({selHi, selMid})
                  2'b00: begin
                    dec.fire = 1'b1; dec.sel = CMD_READ; dec.autoPre = selLo;
                  end
                  2'b10, 2'b11: begin
                    if (selLo) dec.illegal = 1'b1;
                    else begin
                      dec.fire  = 1'b1;
                      dec.train = 1'b1;
                      dec.sel   = selMid ? CMD_RDTRAIN : CMD_FIFOLOAD;
                    end
                  end
                  default: dec.illegal = 1'b1;
                endcase
              end
            end
            PAT_WRITE: begin
              if (selHi && selMid) begin
                if (selLo) dec.illegal = 1'b1;
                else begin
                  dec.fire = 1'b1; dec.train = 1'b1; dec.sel = CMD_WRTRAIN;
                end
              end else begin
                dec.fire     = 1'b1;
                dec.sel      = CMD_WRITE;
                dec.autoPre  = selLo;
                dec.maskKind = selHi ? MASK_DOUBLE : (selMid ? MASK_SINGLE : MASK_NONE);
              end
            end
            default: dec.illegal = 1'b1;
          endcase
        end
      end
    endcase
  end

  // R6: power-down hold decodes nothing
  a_r6_held_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (prevCke && ckeN) |-> (!dec.fire && !dec.illegal));

  // R7: address-training read ignores the select bits
  a_r7_train_read: assert property (@(posedge clk) disable iff (!rstN)
    (addrTrain && !csN && !prevCke && !ckeN && pinPat == PAT_READ)
      |-> (dec.fire && dec.sel == CMD_READ && !dec.autoPre && !dec.train));

endmodule

// File: rtl/gcdec_outreg.sv
module gcdec_outreg
  import gcdec_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  decStrobe_t          dec,
  output logic [NUM_CMDS-1:0] cmdStrobe,
  output logic                illegalCmd,
  output logic                autoPre,
  output logic [MASK_W-1:0]   maskKind,
  output logic                trainActive
);

  logic [NUM_CMDS-1:0] hitVec;

  for (genvar g = 0; g < NUM_CMDS; g++) begin : g_hit
    assign hitVec[g] = dec.fire && (dec.sel == cmdSel_e'(g));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdStrobe   <= '0;
      illegalCmd  <= 1'b0;
      autoPre     <= 1'b0;
      maskKind    <= MASK_NONE;
      trainActive <= 1'b0;
    end else begin
      cmdStrobe   <= hitVec;
      illegalCmd  <= dec.illegal;
      autoPre     <= dec.fire & dec.autoPre;
      maskKind    <= dec.fire ? dec.maskKind : MASK_NONE;
      trainActive <= dec.fire & dec.train;
    end
  end

  a_r9_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(cmdStrobe));

  a_r9_reset_clear: assert property (@(posedge clk)
    !rstN |=> (cmdStrobe == '0 && !illegalCmd && !autoPre));

  a_r8_illegal_silent: assert property (@(posedge clk) disable iff (!rstN)
    illegalCmd |-> (cmdStrobe == '0));

  a_r10_autopre_access: assert property (@(posedge clk) disable iff (!rstN)
    autoPre |-> (cmdStrobe[int'(CMD_READ)] || cmdStrobe[int'(CMD_WRITE)]));

  a_r10_mask_write: assert property (@(posedge clk) disable iff (!rstN)
    (maskKind != MASK_NONE) |-> cmdStrobe[int'(CMD_WRITE)]);

  a_r10_train_kind: assert property (@(posedge clk) disable iff (!rstN)
    trainActive |-> (cmdStrobe[int'(CMD_FIFOLOAD)] || cmdStrobe[int'(CMD_RDTRAIN)]
                     || cmdStrobe[int'(CMD_WRTRAIN)]));

endmodule

// File: rtl/gcdec_top.sv
module gcdec_top
  import gcdec_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                csN,
  input  logic                rasN,
  input  logic                casN,
  input  logic                weN,
  input  logic                ckeN,
  input  logic                selHi,
  input  logic                selMid,
  input  logic                selLo,
  input  logic                addrTrain,
  output logic [NUM_CMDS-1:0] cmdStrobe,
  output logic                illegalCmd,
  output logic                autoPre,
  output logic [MASK_W-1:0]   maskKind,
  output logic                trainActive
);

  localparam logic [NUM_CMDS-1:0] PD_MASK =
    (NUM_CMDS'(1) << int'(CMD_PDENTER)) | (NUM_CMDS'(1) << int'(CMD_PDEXIT));

  decStrobe_t dec;

  gcdec_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .csN(csN), .rasN(rasN), .casN(casN), .weN(weN),
    .ckeN(ckeN), .selHi(selHi), .selMid(selMid), .selLo(selLo),
    .addrTrain(addrTrain), .dec(dec)
  );

  gcdec_outreg u_out (
    .clk(clk), .rstN(rstN), .dec(dec), .cmdStrobe(cmdStrobe),
    .illegalCmd(illegalCmd), .autoPre(autoPre), .maskKind(maskKind),
    .trainActive(trainActive)
  );

  // R1: a deselected edge yields at most a power-state strobe
  a_r1_deselect_quiet: assert property (@(posedge clk) disable iff (!rstN)
    csN |=> (!illegalCmd && (cmdStrobe & ~PD_MASK) == '0));

  // R6: power-down entry only follows a high clock-enable sample
  a_r6_pde_cke: assert property (@(posedge clk) disable iff (!rstN)
    cmdStrobe[int'(CMD_PDENTER)] |-> $past(ckeN));

  // R6: exit only follows a low clock-enable sample
  a_r6_pdx_cke: assert property (@(posedge clk) disable iff (!rstN)
    cmdStrobe[int'(CMD_PDEXIT)] |-> !$past(ckeN));

endmodule

// File: tb/tb_gcdec_top.sv
`timescale 1ns/1ps
module tb_gcdec_top;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1, rasN = 1'b1, casN = 1'b1, weN = 1'b1, ckeN = 1'b0;
  logic selHi = 1'b0, selMid = 1'b0, selLo = 1'b0, addrTrain = 1'b0;
  logic [12:0] cmdStrobe;
  logic illegalCmd, autoPre, trainActive;
  logic [1:0] maskKind;

  int testsRun = 0;
  int testsFailed = 0;
  logic tbPrev = 1'b0;
  logic done = 1'b0;

  always #10 clk = ~clk;

  gcdec_top dut (
    .clk(clk), .rstN(rstN), .csN(csN), .rasN(rasN), .casN(casN), .weN(weN),
    .ckeN(ckeN), .selHi(selHi), .selMid(selMid), .selLo(selLo),
    .addrTrain(addrTrain), .cmdStrobe(cmdStrobe), .illegalCmd(illegalCmd),
    .autoPre(autoPre), .maskKind(maskKind), .trainActive(trainActive)
  );

  typedef struct packed {
    logic [12:0] stb;
    logic        ill;
    logic        ap;
    logic [1:0]  mk;
    logic        tr;
  } expV_t;

  function automatic expV_t model(input logic cs, input logic ras, input logic cas,
                                  input logic we, input logic pc, input logic cc,
                                  input logic hi, input logic mid, input logic lo,
                                  input logic trn);
    expV_t e = '0;
    logic idle = cs | (ras & cas & we);
    if (!pc && cc) begin
      if (idle) e.stb[11] = 1'b1;
      else if (!ras && !cas && we) e.stb[10] = 1'b1;
      else e.ill = 1'b1;
    end else if (pc && !cc) begin
      if (idle) e.stb[12] = 1'b1;
      else e.ill = 1'b1;
    end else if (pc) begin
      e = '0;
    end else if (!idle) begin
      if (!ras && !cas) e.stb[we ? 9 : 0] = 1'b1;
      else if (!ras) begin
        if (we) e.stb[1] = 1'b1;
        else e.stb[lo ? 8 : 7] = 1'b1;
      end else if (cas) e.ill = 1'b1;
      else if (we) begin
        if (trn) e.stb[2] = 1'b1;
        else if (!hi && !mid) begin e.stb[2] = 1'b1; e.ap = lo; end
        else if (hi && !lo) begin e.stb[mid ? 4 : 3] = 1'b1; e.tr = 1'b1; end
        else e.ill = 1'b1;
      end else begin
        if (hi && mid) begin
          if (lo) e.ill = 1'b1;
          else begin e.stb[6] = 1'b1; e.tr = 1'b1; end
        end else begin
          e.stb[5] = 1'b1; e.ap = lo; e.mk = {hi, mid};
        end
      end
    end
    return e;
  endfunction

  function automatic string tagOf(input expV_t e, input logic cs, input logic trn);
    if (e.ill) return "R8";
    if (e.stb[11] || e.stb[12]) return "R6";
    if (e.stb[10]) return "R5";
    if (e.stb[2] && trn) return "R7";
    if (e.stb[2] || e.stb[3] || e.stb[4]) return "R3";
    if (e.stb[5] || e.stb[6]) return "R4";
    if (e.stb != '0) return "R2";
    if (cs) return "R1";
    return "R9";
  endfunction

  task automatic checkOut(input expV_t e, input string tag);
    expV_t got = {cmdStrobe, illegalCmd, autoPre, maskKind, trainActive};
    testsRun++;
    if (got !== e) begin
      testsFailed++;
      $display("FAIL %s: got stb=%b ill=%b ap=%b mk=%0d tr=%b expected stb=%b ill=%b ap=%b mk=%0d tr=%b",
               tag, got.stb, got.ill, got.ap, got.mk, got.tr, e.stb, e.ill, e.ap, e.mk, e.tr);
    end
  endtask

  task automatic apply(input logic cs, input logic ras, input logic cas, input logic we,
                       input logic cke, input logic hi, input logic mid, input logic lo,
                       input logic trn, input string tag);
    expV_t e;
    @(negedge clk);
    csN = cs; rasN = ras; casN = cas; weN = we; ckeN = cke;
    selHi = hi; selMid = mid; selLo = lo; addrTrain = trn;
    e = model(cs, ras, cas, we, tbPrev, cke, hi, mid, lo, trn);
    tbPrev = cke;
    @(posedge clk);
    #1;
    checkOut(e, (tag == "") ? tagOf(e, cs, trn) : tag);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    // R9: reset clears outputs; apply a real command under reset
    repeat (3) @(posedge clk);
    @(negedge clk);
    csN = 1'b0; rasN = 1'b0; casN = 1'b1; weN = 1'b1;
    @(posedge clk); #1;
    checkOut('0, "R9 reset");
    @(negedge clk);
    csN = 1'b1; rasN = 1'b1; casN = 1'b1; weN = 1'b1;
    rstN = 1'b1;
    tbPrev = 1'b0;

    // R2 base commands
    apply(0, 0, 0, 0, 0, 0, 0, 0, 0, "R2 modeset");
    apply(0, 0, 1, 1, 0, 0, 0, 0, 0, "R2 activate");
    apply(1, 1, 1, 1, 0, 0, 0, 0, 0, "R9 one cycle only");
    apply(0, 0, 1, 0, 0, 0, 0, 0, 0, "R2 precharge one");
    apply(0, 0, 1, 0, 0, 0, 0, 1, 0, "R2 precharge all");
    apply(0, 0, 0, 1, 0, 0, 0, 0, 0, "R2 refresh");
    // R1: deselect masks an otherwise legal pattern
    apply(1, 0, 0, 0, 0, 1, 1, 1, 0, "R1 deselect");
    // R3 read group, all select values
    for (int v = 0; v < 8; v++)
      apply(0, 1, 0, 1, 0, v[2], v[1], v[0], 0, "R3 read group");
    // R4 write group, all select values
    for (int v = 0; v < 8; v++)
      apply(0, 1, 0, 0, 0, v[2], v[1], v[0], 0, "R4 write group");
    // R7 training-mode read, all select values
    for (int v = 0; v < 8; v++)
      apply(0, 1, 0, 1, 0, v[2], v[1], v[0], 1, "R7 train read");
    apply(0, 1, 0, 0, 0, 0, 1, 1, 1, "R4 write in train mode");
    // R8 undefined pattern
    apply(0, 1, 1, 0, 0, 0, 0, 0, 0, "R8 pattern 110");
    // R5 self-refresh entry, then held, then exit
    apply(0, 0, 0, 1, 1, 0, 0, 0, 0, "R5 self refresh entry");
    apply(0, 0, 0, 0, 1, 0, 0, 0, 0, "R6 held ignores pins");
    apply(1, 1, 1, 1, 0, 0, 0, 0, 0, "R6 exit");
    // R6 power-down entry with NOP, exit with deselect
    apply(0, 1, 1, 1, 1, 0, 0, 0, 0, "R6 pd entry");
    apply(0, 1, 0, 1, 1, 0, 0, 0, 0, "R6 held read ignored");
    apply(1, 0, 0, 0, 0, 0, 0, 0, 0, "R6 pd exit");
    // R6 illegal commands on transitions
    apply(0, 0, 1, 1, 1, 0, 0, 0, 0, "R6 activate on entry");
    apply(0, 0, 1, 1, 0, 0, 0, 0, 0, "R6 activate on exit");
    // R10 flags drop after access
    apply(0, 1, 0, 0, 0, 1, 0, 1, 0, "R10 masked write ap");
    apply(0, 0, 1, 1, 0, 1, 1, 1, 0, "R10 flags clear on activate");

    // Random mix
    for (int i = 0; i < 4000; i++) begin
      logic [9:0] r = 10'($urandom);
      logic cke = ($urandom_range(0, 99) < 12);
      logic cs  = ($urandom_range(0, 99) < 15);
      logic trn = ($urandom_range(0, 99) < 20);
      apply(cs, r[0], r[1], r[2], cke, r[3], r[4], r[5], trn, "");
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule